// File: doc/BRIEF.md
# Single-Hit Event Frame Builder

This block gathers the time-to-digital results of 32 detector channels over a readout window and, when told to close the window, packs them into one fixed-length event frame. A window spans three consecutive bunch crossings. During the window, each channel may report hits. A report carries a crossing index, which says which of the three crossings it fell in, and a 6-bit fine time. The fine time splits one 25 ns crossing into 64 bins. The block keeps a single hit per channel.

The close strobe does two things in the same clock. It latches a 288-bit frame, made of a caller-supplied 32-bit header and one 8-bit field per channel, and it empties every channel for the next window. The frame is then held on the output until the next close strobe. A one-cycle valid pulse marks each new frame. Frames are expected at roughly 1.1 MHz, which is far below the clock rate. Any number of hit cycles can therefore fall inside one window.

Top module: `evt_frame_builder`

## Requirements
- R1: After reset, frame_vld is 0, the frame output is all zeros, and every channel is empty.
- R2: On a close strobe (win_close=1), the frame takes the header input in bits 31..0. Channel c takes bits 32+8c+7 down to 32+8c, so channel 0 sits in 39..32 and channel 31 in 287..280.
- R3: A channel field holds the crossing code in its upper 2 bits and the 6-bit fine time in its lower 6 bits.
- R4: The crossing code is 0, 1 or 2 for a hit in the first, second or third crossing of the window. Code 3 means no hit, and its fine time is 0x3F, so an empty field reads 0xFF.
- R5: When a channel sees several hits in one window, the hit with the lowest crossing index is kept. Among hits with equal index, the one that arrived first is kept.
- R6: A hit whose crossing index is 3 is ignored.
- R7: frame_vld is 1 in exactly the cycle after each close strobe and 0 otherwise. The frame output does not change except on a close strobe.
- R8: A hit presented in the same cycle as the close strobe belongs to the frame being closed. The following window starts with every channel empty.
- R9: A channel whose hit_vld bit is 0 in a cycle is not changed by that cycle's crossing index or fine time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hit_vld | input | 32 | Per-channel hit present this cycle |
| hit_bx | input | 64 | Per-channel crossing index, 2 bits per channel, channel c at bits 2c+1..2c |
| hit_time | input | 192 | Per-channel fine time, 6 bits per channel, channel c at bits 6c+5..6c |
| hdr | input | 32 | Header word captured into the frame on a close strobe |
| win_close | input | 1 | Close the window and latch a frame |
| frame | output | 288 | Latched event frame |
| frame_vld | output | 1 | One-cycle pulse when a new frame is latched |

## Verification
A wrong per-channel state cannot be seen until the next close strobe. At that point it shows up as a wrong 8-bit field, one clock after the strobe. Such a state could be a crossing code that rose inside a window, a fine time left stale on an empty slot, or a window that was not cleared. For this reason, every stimulus pattern is followed immediately by a close and a full-frame compare. A bad header, misplaced field or wrong valid timing appears on the first frame after reset. A frame that changes between strobes is caught by sampling again one cycle later.

// File: rtl/evt_frame_pkg.sv
package evt_frame_pkg;
    localparam int BX_W     = 2;
    localparam int T_W      = 6;
    localparam int N_BX     = 3;
    localparam int FIELD_W  = BX_W + T_W;
    localparam logic [BX_W-1:0] CODE_NONE = {BX_W{1'b1}};

    typedef struct packed {
        logic [BX_W-1:0] code;
        logic [T_W-1:0]  fine;
    } slot_t;

    localparam slot_t SLOT_EMPTY = '{code: CODE_NONE, fine: {T_W{1'b1}}};
endpackage

// File: rtl/evt_chan_slot.sv
module evt_chan_slot
    import evt_frame_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hit_vld,
    input  logic [BX_W-1:0] hit_bx,
    input  logic [T_W-1:0]  hit_time,
    input  logic            clr,
    output slot_t           field_out
);
    slot_t slot_d, slot_q;
    logic  take;

    always_comb begin
        take   = hit_vld && (hit_bx < BX_W'(N_BX)) && (hit_bx < slot_q.code);
        slot_d = slot_q;
        if (take) begin
            slot_d.code = hit_bx;
            slot_d.fine = hit_time;
        end
        field_out = slot_d;
        if (clr) begin
            slot_d = SLOT_EMPTY;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= SLOT_EMPTY;
        else        slot_q <= slot_d;
    end

    // An empty slot must carry an all-ones fine time
    assert_empty_fine_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.code == CODE_NONE) |-> (slot_q.fine == {T_W{1'b1}}));

    // Inside a window the kept crossing code may only fall
    assert_code_monotone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (slot_q.code <= $past(slot_q.code)));
endmodule

// File: rtl/evt_frame_reg.sv
module evt_frame_reg #(
    parameter int HDR_W   = 32,
    parameter int BODY_W  = 256
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    close_i,
    input  logic [HDR_W-1:0]        hdr_i,
    input  logic [BODY_W-1:0]       body_i,
    output logic [HDR_W+BODY_W-1:0] frame_o,
    output logic                    vld_o
);
    localparam int FRAME_W = HDR_W + BODY_W;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic               vld;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.vld = 1'b0;
        if (close_i) begin
            out_d.frame = {body_i, hdr_i};
            out_d.vld   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign frame_o = out_q.frame;
    assign vld_o   = out_q.vld;

    assert_vld_after_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
        close_i |=> vld_o);

    assert_hold_between_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !close_i |=> (!vld_o && $stable(frame_o)));

    assert_hdr_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        close_i |=> (frame_o[HDR_W-1:0] == $past(hdr_i)));
endmodule

// File: rtl/evt_frame_builder.sv
module evt_frame_builder
    import evt_frame_pkg::*;
#(
    parameter int N_CH  = 32,
    parameter int HDR_W = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [N_CH-1:0]                  hit_vld,
    input  logic [N_CH*BX_W-1:0]             hit_bx,
    input  logic [N_CH*T_W-1:0]              hit_time,
    input  logic [HDR_W-1:0]                 hdr,
    input  logic                             win_close,
    output logic [HDR_W+N_CH*FIELD_W-1:0]    frame,
    output logic                             frame_vld
);
    localparam int BODY_W = N_CH * FIELD_W;

    logic [BODY_W-1:0] body;

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        slot_t fld;
        evt_chan_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit_vld   (hit_vld[c]),
            .hit_bx    (hit_bx[c*BX_W +: BX_W]),
            .hit_time  (hit_time[c*T_W +: T_W]),
            .clr       (win_close),
            .field_out (fld)
        );
        assign body[c*FIELD_W +: FIELD_W] = fld;
    end

    evt_frame_reg #(.HDR_W(HDR_W), .BODY_W(BODY_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .close_i (win_close),
        .hdr_i   (hdr),
        .body_i  (body),
        .frame_o (frame),
        .vld_o   (frame_vld)
    );
endmodule

// File: tb/evt_frame_builder_tb_top.sv
module evt_frame_builder_tb_top;
    localparam int NC = 32;
    localparam int NV = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   hit_vld = '0;
    logic [63:0]   hit_bx = '0;
    logic [191:0]  hit_time = '0;
    logic [31:0]   hdr = '0;
    logic          win_close = 1'b0;
    logic [287:0]  frame;
    logic          frame_vld;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    evt_frame_builder dut_i (
        .clk(clk), .rst_n(rst_n), .hit_vld(hit_vld), .hit_bx(hit_bx),
        .hit_time(hit_time), .hdr(hdr), .win_close(win_close),
        .frame(frame), .frame_vld(frame_vld)
    );

    // {chan[4:0], v1, bx1[1:0], t1[5:0], v2, bx2[1:0], t2[5:0], expected field[7:0]}
    localparam logic [NV-1:0][30:0] VEC = '{
        {5'd2,  1'b0, 2'd0, 6'h00, 1'b0, 2'd0, 6'h00, 8'hFF},
        {5'd20, 1'b1, 2'd3, 6'h00, 1'b1, 2'd1, 6'h33, 8'h73},
        {5'd13, 1'b0, 2'd1, 6'h04, 1'b0, 2'd0, 6'h00, 8'hFF},
        {5'd12, 1'b1, 2'd3, 6'h09, 1'b0, 2'd0, 6'h00, 8'hFF},
        {5'd9,  1'b1, 2'd1, 6'h07, 1'b1, 2'd1, 6'h08, 8'h47},
        {5'd7,  1'b1, 2'd0, 6'h01, 1'b1, 2'd2, 6'h02, 8'h01},
        {5'd5,  1'b1, 2'd2, 6'h10, 1'b1, 2'd0, 6'h11, 8'h11},
        {5'd31, 1'b1, 2'd2, 6'h3F, 1'b0, 2'd0, 6'h00, 8'hBF},
        {5'd1,  1'b1, 2'd1, 6'h2A, 1'b0, 2'd0, 6'h00, 8'h6A},
        {5'd0,  1'b1, 2'd0, 6'h05, 1'b0, 2'd0, 6'h00, 8'h05}
    };

    logic [7:0] exp_f [NC];

    function automatic logic [287:0] build(input logic [31:0] h);
        logic [287:0] f;
        f[31:0] = h;
        for (int c = 0; c < NC; c++) f[32+8*c +: 8] = exp_f[c];
        return f;
    endfunction

    task automatic clear_exp();
        for (int c = 0; c < NC; c++) exp_f[c] = 8'hFF;
    endtask

    task automatic check(input string req, input logic [287:0] act, input logic [287:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic drive_hit(input int ch, input logic v, input logic [1:0] bx, input logic [5:0] t);
        @(negedge clk);
        hit_vld = '0; hit_bx = '0; hit_time = '0;
        hit_vld[ch] = v;
        hit_bx[2*ch +: 2] = bx;
        hit_time[6*ch +: 6] = t;
    endtask

    task automatic close_win(input logic [31:0] h);
        @(negedge clk);
        win_close = 1'b1; hdr = h;
        @(negedge clk);
        win_close = 1'b0;
        hit_vld = '0; hit_bx = '0; hit_time = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [287:0] snap;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 frame", frame, '0);
        check("R1 vld", {287'd0, frame_vld}, '0);
        rst_n = 1'b1;

        // Table walk: R2 R3 R4 R5 R6 R9
        for (int i = 0; i < NV; i++) begin
            int ch;
            ch = int'(VEC[i][30:26]);
            drive_hit(ch, VEC[i][25], VEC[i][24:23], VEC[i][22:17]);
            drive_hit(ch, VEC[i][16], VEC[i][15:14], VEC[i][13:8]);
            @(negedge clk); hit_vld = '0;
            close_win(32'hA500_0000 + i);
            clear_exp();
            exp_f[ch] = VEC[i][7:0];
            check("R2/R3/R4/R5/R6/R9 vector", frame, build(32'hA500_0000 + i));
            check("R7 vld pulse", {287'd0, frame_vld}, 288'd1);
        end

        // R7: hold stable, vld low one cycle later
        snap = frame;
        @(negedge clk);
        check("R7 hold", frame, snap);
        check("R7 vld low", {287'd0, frame_vld}, '0);

        // R2: many channels at once
        clear_exp();
        @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            hit_vld[c] = 1'b1;
            hit_bx[2*c +: 2] = 2'(c % 3);
            hit_time[6*c +: 6] = 6'(c + 3);
            exp_f[c] = {2'(c % 3), 6'(c + 3)};
        end
        close_win(32'hDEAD_BEEF);
        check("R2 all channels", frame, build(32'hDEAD_BEEF));

        // R8: hit in the closing cycle included, next window empty
        @(negedge clk);
        clear_exp();
        win_close = 1'b1; hdr = 32'h1111_2222;
        hit_vld[4] = 1'b1; hit_bx[9:8] = 2'd1; hit_time[29:24] = 6'h2C;
        @(negedge clk);
        win_close = 1'b0; hit_vld = '0; hit_bx = '0; hit_time = '0;
        exp_f[4] = 8'h6C;
        check("R8 closing-cycle hit", frame, build(32'h1111_2222));
        // back-to-back close with an empty window
        close_win(32'h3333_4444);
        clear_exp();
        check("R8 next window empty", frame, build(32'h3333_4444));
        check("R7 vld again", {287'd0, frame_vld}, 288'd1);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule